// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

After reset this block owns the SDRAM command and control pins and steps them through the start-up sequence that a synchronous DRAM needs before normal use. It keeps the clock enable and byte masks high and sends no-operation commands for a settling pause. It then closes every bank with a precharge-all. Next comes a counted run of auto-refresh commands, and last it loads the mode register with a word built from parameters: burst length code, burst type, CAS latency and write-burst policy. Each command is followed by its own recovery gap, measured in clock cycles and set by a parameter.

When the recovery after the mode register load has elapsed, the block raises a completion flag that stays high until the next reset. The main memory controller waits for that flag and then takes over the pins. Every pin output comes straight from a flop, so the pins can be placed in I/O registers.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high, and during the pause after it, the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), clock enable is 1, every byte-mask bit is 1 and init_done is 0.
- R2: At the rising edge number PAUSE_CYC after reset is released, the pins show precharge-all for one cycle: cs_n=0, ras_n=0, cas_n=1, we_n=0, address bit 10 = 1, all other address bits and the bank bits 0.
- R3: Exactly REF_COUNT auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1) follow. The first comes T_RP_CYC cycles after the precharge-all, and each later one T_RC_CYC cycles after the one before it.
- R4: T_RC_CYC cycles after the last refresh the pins show a mode register load for one cycle: cs_n, ras_n, cas_n and we_n all 0, with the bank bits 0.
- R5: The address during the mode register load carries the burst length code on bits 2:0, the burst type on bit 3 (1 = interleaved), the CAS latency on bits 6:4 (3'b010 for 2, 3'b011 for 3) and the single-write flag on bit 9. Bits 7, 8, 10 and everything above bit 10 are 0.
- R6: Every cycle that is not one of the command cycles in R2 to R4 shows NOP with address and bank 0.
- R7: init_done rises T_RSC_CYC cycles after the mode register load cycle, stays high until reset, and while it is high the pins show NOP.
- R8: Reset raised at any point clears init_done and returns the pins to NOP on the next edge. When reset falls again, the whole sequence starts over from the pause.
- R9: Clock enable is 1 in every cycle, both during reset and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sd_cke | output | 1 | Clock enable to the SDRAM |
| sd_dqm | output | DQM_W | Byte masks, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address lines (A10 flag, mode word) |
| sd_ba | output | BANK_W | Bank select lines, driven 0 |
| init_done | output | 1 | High once the sequence is complete |

## Verification
The bench builds the block with a 20-cycle pause, T_RP_CYC=3, T_RC_CYC=5, T_RSC_CYC=2, eight refreshes, CAS latency 3, burst code 3'b011 and interleaved bursts. With these values the full sequence ends at edge 65, so every cycle of it can be compared against a table of expected command edges. Setting the burst type to interleaved makes a nonzero bit 3 visible in the mode word, next to the latency and length fields. The run covers a reset that lands in the middle of the refresh loop and a reset after completion, and in both cases it checks that the full timeline is replayed.

// File: rtl/boot_pkg.sv
package boot_pkg;

  // Command encoding as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_t;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_DONE
  } step_t;

  // Builds the 11-bit mode word; reserved positions stay zero.
  function automatic logic [10:0] mode_word(input logic [2:0] bl_code,
                                            input logic       ilv,
                                            input int         cas_lat,
                                            input logic       single_wr);
    logic [10:0] w;
    w      = '0;
    w[2:0] = bl_code;
    w[3]   = ilv;
    w[6:4] = (cas_lat == 2) ? 3'b010 : 3'b011;
    w[9]   = single_wr;
    return w;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/boot_slot_timer.sv
module boot_slot_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  // Slot of length 'limit' ends on the edge where cnt equals limit-1
  assign expire = (cnt == (limit - 1'b1));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/boot_pin_drive.sv
module boot_pin_drive
  import boot_pkg::*;
#(
  parameter int                ADDR_W    = 11,
  parameter int                BANK_W    = 2,
  parameter int                DQM_W     = 4,
  parameter logic [ADDR_W-1:0] MODE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  cmd_t              cmd_d,
  input  logic              done_d,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic [3:0]        cmd_pins,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              done
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(11'h400);

  cmd_t cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_NOP;
      addr  <= '0;
      ba    <= '0;
      cke   <= 1'b1;
      dqm   <= '1;
      done  <= 1'b0;
    end else begin
      cke  <= 1'b1;
      dqm  <= '1;
      ba   <= '0;
      done <= done_d;
      if (issue) begin
        cmd_q <= cmd_d;
        case (cmd_d)
          CMD_PRE: addr <= ALL_BANKS;
          CMD_MRS: addr <= MODE_ADDR;
          default: addr <= '0;
        endcase
      end else begin
        cmd_q <= CMD_NOP;
        addr  <= '0;
      end
    end
  end

  assign cmd_pins = cmd_q;

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import boot_pkg::*;
#(
  parameter int       ADDR_W       = 11,
  parameter int       BANK_W       = 2,
  parameter int       DQM_W        = 4,
  parameter int       PAUSE_CYC    = 20000,
  parameter int       T_RP_CYC     = 3,
  parameter int       T_RC_CYC     = 7,
  parameter int       T_RSC_CYC    = 2,
  parameter int       REF_COUNT    = 8,
  parameter int       CAS_LAT      = 3,
  parameter logic [2:0] BL_CODE    = 3'b011,
  parameter bit       INTERLEAVE   = 1'b0,
  parameter bit       SINGLE_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              init_done
);

  localparam int CNT_MAX = max4(PAUSE_CYC, T_RP_CYC, T_RC_CYC, T_RSC_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int REF_W   = (REF_COUNT > 1) ? $clog2(REF_COUNT) : 1;
  localparam logic [10:0]       MODE11    = mode_word(BL_CODE, INTERLEAVE, CAS_LAT, SINGLE_WRITE);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE11);

  step_t            state, state_d;
  logic [REF_W-1:0] ref_cnt, ref_d;
  logic [CNT_W-1:0] limit;
  logic             expire;
  logic             issue;
  cmd_t             cmd_sel;
  logic [3:0]       cmd_pins;

  always_comb begin
    state_d = state;
    ref_d   = ref_cnt;
    issue   = 1'b0;
    cmd_sel = CMD_NOP;
    limit   = CNT_W'(1);
    case (state)
      ST_PAUSE: begin
        limit = CNT_W'(PAUSE_CYC);
        if (expire) begin
          state_d = ST_PRE;
          issue   = 1'b1;
          cmd_sel = CMD_PRE;
        end
      end
      ST_PRE: begin
        limit = CNT_W'(T_RP_CYC);
        if (expire) begin
          state_d = ST_REF;
          ref_d   = '0;
          issue   = 1'b1;
          cmd_sel = CMD_REF;
        end
      end
      ST_REF: begin
        limit = CNT_W'(T_RC_CYC);
        if (expire) begin
          issue = 1'b1;
          if (ref_cnt == REF_W'(REF_COUNT - 1)) begin
            state_d = ST_MRS;
            cmd_sel = CMD_MRS;
          end else begin
            ref_d   = ref_cnt + 1'b1;
            cmd_sel = CMD_REF;
          end
        end
      end
      ST_MRS: begin
        limit = CNT_W'(T_RSC_CYC);
        if (expire) state_d = ST_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_PAUSE;
      ref_cnt <= '0;
    end else begin
      state   <= state_d;
      ref_cnt <= ref_d;
    end
  end

  boot_slot_timer #(.CNT_W(CNT_W)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (expire || (state == ST_DONE)),
    .limit  (limit),
    .expire (expire)
  );

  boot_pin_drive #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .DQM_W     (DQM_W),
    .MODE_ADDR (MODE_ADDR)
  ) i_drive (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .cmd_d    (cmd_sel),
    .done_d   (state_d == ST_DONE),
    .cke      (sd_cke),
    .dqm      (sd_dqm),
    .cmd_pins (cmd_pins),
    .addr     (sd_addr),
    .ba       (sd_ba),
    .done     (init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins;

endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker #(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2,
  parameter int DQM_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cke,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BANK_W-1:0] sd_ba,
  input logic              init_done
);

  logic [3:0] cmd;
  logic       is_pre, is_mrs, is_nop;
  assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_pre = (cmd == 4'b0010);
  assign is_mrs = (cmd == 4'b0000);
  assign is_nop = (cmd == 4'b0111);

  p_mask_high_r1: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (&sd_dqm));

  p_pre_all_r2: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> (sd_addr == ADDR_W'(11'h400)) && (sd_ba == '0));

  p_mrs_bank_r4: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (sd_ba == '0));

  p_mrs_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> !sd_addr[10] && !sd_addr[8] && !sd_addr[7] && ((sd_addr >> 11) == '0)
               && ((sd_addr[6:4] == 3'b010) || (sd_addr[6:4] == 3'b011)));

  p_pre_single_r6: assert property (@(posedge clk) disable iff (rst)
    is_pre |=> !is_pre);

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    init_done |-> is_nop);

  p_cke_high_r9: assert property (@(posedge clk) disable iff (rst)
    sd_cke);

endmodule

bind sdram_boot_seq boot_seq_checker #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .DQM_W  (DQM_W)
) i_boot_chk (
  .clk       (clk),
  .rst       (rst),
  .sd_cke    (sd_cke),
  .sd_dqm    (sd_dqm),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_addr   (sd_addr),
  .sd_ba     (sd_ba),
  .init_done (init_done)
);

// File: tb/test_sdram_boot_seq.sv
module test_sdram_boot_seq;

  localparam int NEV      = 10;
  localparam int DONE_AT  = 65;
  localparam int EV_EDGE [NEV] = '{20, 23, 28, 33, 38, 43, 48, 53, 58, 63};
  localparam logic [3:0] EV_CMD [NEV] = '{4'b0010,
    4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001,
    4'b0000};
  localparam logic [10:0] MODE_EXP = 11'h03B;
  localparam logic [3:0]  NOP      = 4'b0111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sd_cke;
  logic [3:0]  sd_dqm;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [10:0] sd_addr;
  logic [1:0]  sd_ba;
  logic        init_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sdram_boot_seq #(
    .ADDR_W(11), .BANK_W(2), .DQM_W(4),
    .PAUSE_CYC(20), .T_RP_CYC(3), .T_RC_CYC(5), .T_RSC_CYC(2),
    .REF_COUNT(8), .CAS_LAT(3), .BL_CODE(3'b011),
    .INTERLEAVE(1'b1), .SINGLE_WRITE(1'b0)
  ) i_sdram_boot_seq (
    .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_dqm(sd_dqm),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba), .init_done(init_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Walks edges 1..upto after reset release, comparing pins to the event table
  task automatic walk(input int upto);
    for (int e = 1; e <= upto; e++) begin
      logic [3:0] exp_cmd;
      string      tag;
      @(posedge clk);
      @(negedge clk);
      exp_cmd = NOP;
      for (int k = 0; k < NEV; k++)
        if (EV_EDGE[k] == e) exp_cmd = EV_CMD[k];
      case (exp_cmd)
        4'b0010: tag = "R2 precharge-all";
        4'b0001: tag = "R3 refresh";
        4'b0000: tag = "R4 mode load";
        default: tag = "R6 nop";
      endcase
      chk(tag, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, exp_cmd);
      chk("R6 bank zero", sd_ba, 2'b00);
      if (exp_cmd == 4'b0010)      chk("R2 A10 set", sd_addr, 11'h400);
      else if (exp_cmd == 4'b0000) chk("R5 mode word", sd_addr, MODE_EXP);
      else                         chk("R6 addr zero", sd_addr, 11'h000);
      chk("R7 init_done timing", init_done, (e >= DONE_AT) ? 1 : 0);
      chk("R9 cke high", sd_cke, 1);
      if (e < DONE_AT) chk("R1 dqm high", sd_dqm, 4'hF);
    end
  endtask

  task automatic check_reset_state(input string req);
    chk(req, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, NOP);
    chk(req, init_done, 0);
    chk("R9 cke during reset", sd_cke, 1);
    chk("R1 dqm during reset", sd_dqm, 4'hF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1 reset state");
    rst = 1'b0;
    // R8: interrupt in the middle of the refresh loop
    walk(40);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state("R8 reset mid-sequence");
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    walk(80);
    // R7: flag stays high and pins stay idle after completion
    for (int i = 0; i < 30; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R7 done sticky", init_done, 1);
      chk("R7 idle after done", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, NOP);
    end
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state("R8 reset after done");
    rst = 1'b0;
    walk(DONE_AT + 2);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before end of run");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule